// File: doc/BRIEF.md
# Interleaved Raster Display Address Generator

This block turns a fetch request for one byte of a 256x192 one-bit-per-pixel bitmap into the memory addresses a video fetch engine must read. A request carries an active line number and a byte column. Each accepted request produces one result with a 16-bit pixel byte address, a 16-bit colour attribute byte address, an attribute-enable flag and a buffer flag for high-resolution columns. Pixel rows are not stored linearly. The line number is split into a screen third (bits 7:6), a character row within the third (bits 5:3) and a pixel line within the cell (bits 2:0). The stored offset is then third, cell line, character row and byte column, from most significant to least significant.

A 3-bit display mode field is written by any I/O write whose low address byte is 0xFF. The mode moves the pixel and attribute areas to another base, gives attributes the same interleaved per-line layout, or selects a 512-wide mode that takes pixel columns alternately from two buffers.

The request side and the result side are valid/ready streams. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result that is offered and not taken stays unchanged until `res_ready` is high. A request outside the visible area is taken and dropped, so no fetch is issued for it.

Top module: `raster_addr_gen`

## Requirements
- R1: With mode 000 the pixel address is 0x4000 + third*2048 + cellline*256 + charrow*32 + column. Here third = line[7:6], charrow = line[5:3], cellline = line[2:0] and column = col[4:0].
- R2: With mode 000 the attribute address is 0x5800 + (line>>3)*32 + column, `res_attr_en` is 1 and `res_buf` is 0.
- R3: Mode 001 uses base 0x6000 instead of 0x4000 for both areas. The pixel address uses the R1 layout from 0x6000, and the attribute address is 0x7800 + (line>>3)*32 + column.
- R4: Mode 010 keeps pixels at the R1 addresses. The attribute address is 0x6000 plus the same interleaved offset as the pixel data.
- R5: Mode 110 is high resolution with 64 byte columns. col[0] selects the pixel buffer (0: base 0x4000, 1: base 0x6000), col[5:1] is the byte column, and `res_buf` equals col[0]. `res_attr_en` is 0 and `res_attr_addr` is 0.
- R6: An I/O write (`io_wr` high) with `io_addr[7:0]` = 0xFF loads `io_wdata[2:0]` into the mode. The upper address byte and `io_wdata[7:3]` are ignored. Writes to any other low byte leave the mode unchanged. A request taken in the same cycle as a mode write uses the old mode.
- R7: Mode values 011, 100, 101 and 111 give exactly the mode 000 results.
- R8: A taken request with line >= 192, or with col >= 32 in a mode other than 110, produces no result.
- R9: A request taken at a clock edge appears on the result outputs with `res_valid` high right after that edge. The latency is one cycle.
- R10: `req_ready` = !res_valid || res_ready. While `res_valid` is high and `res_ready` is low, every result output holds its value.
- R11: Reset makes the mode 000 and `res_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted |
| req_line | input | 8 | Active line number |
| req_col | input | 6 | Byte column (0-31, or 0-63 in mode 110) |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken downstream |
| res_pix_addr | output | 16 | Pixel byte address |
| res_attr_addr | output | 16 | Attribute byte address (0 when disabled) |
| res_attr_en | output | 1 | Attribute fetch required |
| res_buf | output | 1 | High-resolution source buffer (0: low base, 1: high base) |

## Verification
Assertions check four behaviours on every cycle. The mode changes only on a matching port write and then loads the written field. Results hold steady under back-pressure. Every taken visible request produces a result after one cycle and every invisible one produces nothing. A result without attributes carries a zero attribute address. Only the bench scenarios can show that the address values are correct: the interleave of third, cell line and row, the attribute layouts of each mode, the alternating buffer choice in high resolution, and the fallback of unlisted mode codes. The bench also confirms that a write to another port does not change any address.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int ADDR_W = 16;
  localparam int LINE_W = 8;
  localparam int COL_W  = 6;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_STD    = 3'b000;
  localparam logic [MODE_W-1:0] MODE_ALTBUF = 3'b001;
  localparam logic [MODE_W-1:0] MODE_HICOL  = 3'b010;
  localparam logic [MODE_W-1:0] MODE_HIRES  = 3'b110;

  typedef struct packed {
    logic [ADDR_W-1:0] pix;
    logic [ADDR_W-1:0] attr;
    logic              attr_en;
    logic              buf_sel;
  } fetch_t;
endpackage

// File: rtl/mode_latch.sv
module mode_latch #(
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MODE_W  = 3,
  parameter logic [7:0] PORT_LO = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [MODE_W-1:0] mode
);
  logic hit;
  assign hit = io_wr && (io_addr[7:0] == PORT_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= '0;
    else if (hit) mode <= io_wdata[MODE_W-1:0];
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(mode)); // R6
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> mode == $past(io_wdata[MODE_W-1:0])); // R6
endmodule

// File: rtl/raster_addr_calc.sv
module raster_addr_calc
  import raster_pkg::*;
#(
  parameter int ACTIVE_LINES = 192,
  parameter int BYTE_COLS    = 32,
  parameter logic [ADDR_W-1:0] BASE_LO  = 16'h4000,
  parameter logic [ADDR_W-1:0] BASE_HI  = 16'h6000,
  parameter logic [ADDR_W-1:0] ATTR_OFS = 16'h1800
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [LINE_W-1:0] line,
  input  logic [COL_W-1:0]  col,
  output fetch_t            fetch,
  output logic              visible
);
  localparam int BCOL_W = $clog2(BYTE_COLS);
  localparam int ILV_W  = LINE_W + BCOL_W;
  localparam int LIN_W  = LINE_W - 3 + BCOL_W;

  logic              hires, hicol, alt;
  logic [BCOL_W-1:0] bcol;
  logic [ILV_W-1:0]  ilv;
  logic [LIN_W-1:0]  lin;
  logic [ADDR_W-1:0] base;

  always_comb begin
    hires = (mode == MODE_HIRES);
    hicol = (mode == MODE_HICOL);
    alt   = (mode == MODE_ALTBUF);
    bcol  = hires ? col[BCOL_W:1] : col[BCOL_W-1:0];
    // third, line in cell, row in third, byte column
    ilv   = {line[7:6], line[2:0], line[5:3], bcol};
    lin   = {line[LINE_W-1:3], bcol};
    base  = (alt || (hires && col[0])) ? BASE_HI : BASE_LO;

    fetch.pix     = base + ADDR_W'(ilv);
    fetch.buf_sel = hires && col[0];
    fetch.attr_en = !hires;
    if (hires)      fetch.attr = '0;
    else if (hicol) fetch.attr = BASE_HI + ADDR_W'(ilv);
    else            fetch.attr = base + ATTR_OFS + ADDR_W'(lin);

    visible = (32'(line) < ACTIVE_LINES) && (hires || (32'(col) < BYTE_COLS));
  end
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_keep,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= take && in_keep;
      if (take && in_keep) out_data <= in_data;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_DROP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_keep |=> !out_valid); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_keep |=> out_valid); // R9
endmodule

// File: rtl/raster_addr_gen.sv
module raster_addr_gen
  import raster_pkg::*;
#(
  parameter int ACTIVE_LINES = 192,
  parameter int BYTE_COLS    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic [15:0]        io_addr,
  input  logic [7:0]         io_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LINE_W-1:0]  req_line,
  input  logic [COL_W-1:0]   req_col,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ADDR_W-1:0]  res_pix_addr,
  output logic [ADDR_W-1:0]  res_attr_addr,
  output logic               res_attr_en,
  output logic               res_buf
);
  localparam int FW = $bits(fetch_t);

  logic [MODE_W-1:0] mode;
  fetch_t            nxt, cur;
  logic              visible;

  mode_latch #(.PORT_W(16), .DATA_W(8), .MODE_W(MODE_W), .PORT_LO(8'hFF)) u_mode (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mode(mode)
  );

  raster_addr_calc #(.ACTIVE_LINES(ACTIVE_LINES), .BYTE_COLS(BYTE_COLS)) u_calc (
    .mode(mode), .line(req_line), .col(req_col), .fetch(nxt), .visible(visible)
  );

  fetch_stage #(.W(FW)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_keep(visible), .in_data(nxt), .out_valid(res_valid),
    .out_ready(res_ready), .out_data(cur)
  );

  assign res_pix_addr  = cur.pix;
  assign res_attr_addr = cur.attr;
  assign res_attr_en   = cur.attr_en;
  assign res_buf       = cur.buf_sel;

  AST_NO_ATTR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_attr_en |-> res_attr_addr == '0); // R5
  AST_PIX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_pix_addr[15:13] == 3'b010 || res_pix_addr[15:13] == 3'b011); // R1
  AST_BUF_NEEDS_HIRES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_buf |-> !res_attr_en); // R5
endmodule

// File: tb/tb_raster_addr_gen.sv
module tb_raster_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_line = '0;
  logic [5:0]  req_col = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_pix_addr, res_attr_addr;
  logic        res_attr_en, res_buf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  raster_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_col(req_col),
    .res_valid(res_valid), .res_ready(res_ready), .res_pix_addr(res_pix_addr),
    .res_attr_addr(res_attr_addr), .res_attr_en(res_attr_en), .res_buf(res_buf)
  );

  // mode, line, col, pix, attr, attr_en, buf
  localparam int NV = 16;
  localparam logic [50:0] VEC [0:NV-1] = '{
    {3'd0, 8'd0,   6'd0,  16'h4000, 16'h5800, 1'b1, 1'b0}, // R1 R2
    {3'd0, 8'd1,   6'd0,  16'h4100, 16'h5800, 1'b1, 1'b0}, // R1
    {3'd0, 8'd8,   6'd0,  16'h4020, 16'h5820, 1'b1, 1'b0}, // R1 R2
    {3'd0, 8'd64,  6'd5,  16'h4805, 16'h5905, 1'b1, 1'b0}, // R1 R2
    {3'd0, 8'd191, 6'd31, 16'h57FF, 16'h5AFF, 1'b1, 1'b0}, // R1 R2
    {3'd1, 8'd191, 6'd31, 16'h77FF, 16'h7AFF, 1'b1, 1'b0}, // R3
    {3'd1, 8'd9,   6'd3,  16'h6123, 16'h7823, 1'b1, 1'b0}, // R3
    {3'd2, 8'd77,  6'd10, 16'h4D2A, 16'h6D2A, 1'b1, 1'b0}, // R4
    {3'd2, 8'd191, 6'd31, 16'h57FF, 16'h77FF, 1'b1, 1'b0}, // R4
    {3'd6, 8'd0,   6'd0,  16'h4000, 16'h0000, 1'b0, 1'b0}, // R5
    {3'd6, 8'd0,   6'd1,  16'h6000, 16'h0000, 1'b0, 1'b1}, // R5
    {3'd6, 8'd191, 6'd63, 16'h77FF, 16'h0000, 1'b0, 1'b1}, // R5
    {3'd6, 8'd130, 6'd20, 16'h520A, 16'h0000, 1'b0, 1'b0}, // R5
    {3'd3, 8'd8,   6'd0,  16'h4020, 16'h5820, 1'b1, 1'b0}, // R7
    {3'd5, 8'd64,  6'd5,  16'h4805, 16'h5905, 1'b1, 1'b0}, // R7
    {3'd7, 8'd191, 6'd31, 16'h57FF, 16'h5AFF, 1'b1, 1'b0}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // drive one request; on return the result of the edge is visible
  task automatic request(input logic [7:0] ln, input logic [5:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_line = ln; req_col = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 res_valid in reset", 32'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 res_valid after reset", 32'(res_valid), 0);
    chk("R10 req_ready idle", 32'(req_ready), 1);
    // R11: default mode is standard
    request(8'd8, 6'd0);
    chk("R11 default mode pix", 32'(res_pix_addr), 32'h4020);
    chk("R9 valid one cycle after", 32'(res_valid), 1);
    @(negedge clk);
    chk("R9 valid drops without request", 32'(res_valid), 0);

    for (int i = 0; i < NV; i++) begin
      io_write(16'h00FF, {5'b0, VEC[i][50:48]});
      request(VEC[i][47:40], VEC[i][39:34]);
      chk($sformatf("R9 vec%0d valid", i), 32'(res_valid), 1);
      chk($sformatf("R1/R3/R4/R5/R7 vec%0d pix", i), 32'(res_pix_addr), 32'(VEC[i][33:18]));
      chk($sformatf("R2/R3/R4/R5 vec%0d attr", i), 32'(res_attr_addr), 32'(VEC[i][17:2]));
      chk($sformatf("R2/R5 vec%0d attr_en", i), 32'(res_attr_en), 32'(VEC[i][1]));
      chk($sformatf("R5 vec%0d buf", i), 32'(res_buf), 32'(VEC[i][0]));
    end

    // R6: other port ignored, high bits ignored
    io_write(16'h0000, 8'h00);
    io_write(16'h00FE, 8'h01);
    request(8'd0, 6'd0);
    chk("R6 other port ignored", 32'(res_pix_addr), 32'h4000);
    io_write(16'h12FF, 8'hF9);
    request(8'd0, 6'd0);
    chk("R6 upper bits ignored", 32'(res_pix_addr), 32'h6000);
    chk("R6 upper bits attr", 32'(res_attr_addr), 32'h7800);

    // R6: request in same cycle as write uses old mode (old = 001)
    @(negedge clk);
    io_wr = 1'b1; io_addr = 16'h00FF; io_wdata = 8'h00;
    req_valid = 1'b1; req_line = 8'd0; req_col = 6'd0;
    @(negedge clk);
    io_wr = 1'b0; req_valid = 1'b0;
    chk("R6 same-cycle old mode", 32'(res_pix_addr), 32'h6000);
    request(8'd0, 6'd0);
    chk("R6 new mode afterwards", 32'(res_pix_addr), 32'h4000);

    // R8: invisible requests
    request(8'd192, 6'd0);
    chk("R8 line 192 dropped", 32'(res_valid), 0);
    request(8'd255, 6'd3);
    chk("R8 line 255 dropped", 32'(res_valid), 0);
    request(8'd10, 6'd40);
    chk("R8 col 40 dropped in std", 32'(res_valid), 0);
    io_write(16'h00FF, 8'h06);
    request(8'd10, 6'd40);
    chk("R8 col 40 kept in hires", 32'(res_valid), 1);
    request(8'd192, 6'd1);
    chk("R8 line 192 dropped in hires", 32'(res_valid), 0);
    io_write(16'h00FF, 8'h00);

    // R10: back-pressure
    res_ready = 1'b0;
    request(8'd64, 6'd5);
    chk("R10 stalled valid", 32'(res_valid), 1);
    chk("R10 ready low when full", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b1; req_line = 8'd191; req_col = 6'd31;
    @(negedge clk);
    chk("R10 held pix", 32'(res_pix_addr), 32'h4805);
    chk("R10 held attr", 32'(res_attr_addr), 32'h5905);
    chk("R10 held valid", 32'(res_valid), 1);
    res_ready = 1'b1;
    #0;
    chk("R10 ready follows res_ready", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next after drain", 32'(res_pix_addr), 32'h57FF);
    @(negedge clk);
    chk("R10 empty after drain", 32'(res_valid), 0);

    // R11: reset restores mode 000
    io_write(16'h00FF, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 valid clear", 32'(res_valid), 0);
    request(8'd0, 6'd0);
    chk("R11 mode back to 000", 32'(res_pix_addr), 32'h4000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule